// File: doc/BRIEF.md
# Boundary-Scanned Dual Bidirectional Bus Transceiver

This block is a pair of 9-bit non-inverting bidirectional buffer groups. Each group has its own active-low enable and its own direction input, and the two groups do not affect each other. A group whose enable is high turns off both of its sides. A group whose enable is low drives its A side onto its B side when its direction input is high, and its B side onto its A side when the direction input is low. Each pad is modelled as three signals: data in, data out and a per-group output enable.

An 80-cell serial test register surrounds the buffers. An external test controller supplies three strobes (capture, shift, update), a pad-mode select and serial data in. Capture and shift act on the rising clock edge. The update latches and the serial output change on the falling edge. In latch mode the pads take their data and their enables from the update latches. In off mode every enable is forced low. Mode codes 0 and 3 leave the pads on the functional path.

Top module: `scan_bus_xcvr`

## Requirements
- R1: In functional mode, a group whose enable input is 1 has both its A-side and its B-side enable outputs at 0.
- R2: In functional mode, a group whose enable input is 0 drives B (bEn=1, aEn=0) when its direction input is 1, and drives A (aEn=1, bEn=0) when its direction input is 0. In modes 0, 2 and 3, aOut always carries bIn and bOut always carries aIn.
- R3: Group 0 (bits 8:0 of each data bus, index 0 of each enable and direction bus) and group 1 (bits 17:9, index 1) behave independently of each other.
- R4: A capture loads all 80 cells. Cells 79-4g, 78-4g, 77-4g and 76-4g hold group g's direction input, its enable input, its functional A-enable (~en & ~dir) and its functional B-enable (~en & dir). For pin k = 9g+i, the A input goes to cell 71-k, the functional B output to cell 53-k, the B input to cell 35-k and the functional A output to cell 17-k.
- R5: A shift moves the chain one cell toward cell 0 and loads scanIn into cell 79. scanOut shows cell 0, refreshed on each falling edge, so the captured cell i appears after i shifts.
- R6: An update, taken on the falling edge, copies the chain into the latches. Without an update the latches keep their value, even while the chain shifts.
- R7: In mode 1 (latch), aEn[g]=latch[77-4g], bEn[g]=latch[76-4g], bOut[k]=latch[53-k] and aOut[k]=latch[17-k].
- R8: In mode 0, capture, shift and update leave the pads unchanged.
- R9: In mode 2 (off), every enable output is 0. Mode 3 behaves as mode 0.
- R10: Reset clears the chain, the latches and scanOut to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock: capture and shift on the rising edge, update and scanOut on the falling edge |
| trstN | input | 1 | Asynchronous active-low reset |
| grpEnN | input | 2 | Active-low enable, one bit per group |
| grpDir | input | 2 | Direction per group, 1 = A to B |
| aIn | input | 18 | A-side pad receive data |
| bIn | input | 18 | B-side pad receive data |
| aOut | output | 18 | A-side pad drive data |
| bOut | output | 18 | B-side pad drive data |
| aEn | output | 2 | A-side pad enable, one bit per group |
| bEn | output | 2 | B-side pad enable, one bit per group |
| capture | input | 1 | Capture strobe |
| shift | input | 1 | Shift strobe |
| update | input | 1 | Update strobe |
| mode | input | 2 | Pad mode: 0 functional, 1 latch, 2 off, 3 functional |
| scanIn | input | 1 | Serial data in, enters cell 79 |
| scanOut | output | 1 | Serial data out, taken from cell 0 |

## Verification
Assertions check the following on every clock:
- A disabled group never enables either side.
- A functional group never enables both of its sides at once.
- Off mode holds every enable low.
- Each shift moves the chain by exactly one cell.
- The latches stay still on any falling edge without an update.

Only the bench scenarios can show the exact 80-cell capture map, the serial order at scanOut, the cell-to-pad decoding in latch mode, and the fact that scan activity in functional mode leaves the pads undisturbed.

// File: rtl/scan_xcvr_pkg.sv
`timescale 1ns/1ps
package scan_xcvr_pkg;
  typedef enum logic [1:0] {
    MODE_FUNC  = 2'd0,
    MODE_LATCH = 2'd1,
    MODE_OFF   = 2'd2,
    MODE_SPARE = 2'd3
  } padMode_e;

  typedef struct packed {
    logic cap;
    logic sh;
    logic upd;
    logic useLatch;
    logic forceOff;
  } scanCtl_t;
endpackage

// File: rtl/xcvr_func.sv
`timescale 1ns/1ps
module xcvr_func #(
  parameter int GROUPS = 2,
  parameter int GBITS  = 9,
  localparam int W = GROUPS * GBITS
) (
  input  logic [GROUPS-1:0] enN,
  input  logic [GROUPS-1:0] dir,
  input  logic [W-1:0]      aIn,
  input  logic [W-1:0]      bIn,
  output logic [GROUPS-1:0] aOeF,
  output logic [GROUPS-1:0] bOeF,
  output logic [W-1:0]      aDatF,
  output logic [W-1:0]      bDatF
);
  for (genvar g = 0; g < GROUPS; g++) begin : gGrp
    assign aOeF[g] = ~enN[g] & ~dir[g];
    assign bOeF[g] = ~enN[g] &  dir[g];
    assign aDatF[g*GBITS +: GBITS] = bIn[g*GBITS +: GBITS];
    assign bDatF[g*GBITS +: GBITS] = aIn[g*GBITS +: GBITS];
  end
endmodule

// File: rtl/scan_ctrl.sv
`timescale 1ns/1ps
module scan_ctrl
  import scan_xcvr_pkg::*;
(
  input  logic       capture,
  input  logic       shift,
  input  logic       update,
  input  logic [1:0] mode,
  output scanCtl_t   ctl
);
  padMode_e padMode;
  assign padMode = padMode_e'(mode);

  always_comb begin
    ctl.cap      = capture;
    ctl.sh       = shift & ~capture;   // capture takes precedence
    ctl.upd      = update;
    ctl.useLatch = (padMode == MODE_LATCH);
    ctl.forceOff = (padMode == MODE_OFF);
  end
endmodule

// File: rtl/scan_path.sv
`timescale 1ns/1ps
module scan_path
  import scan_xcvr_pkg::*;
#(
  parameter int GROUPS = 2,
  parameter int GBITS  = 9,
  localparam int W  = GROUPS * GBITS,
  localparam int CH = 4 * GROUPS + 4 * W
) (
  input  logic              tck,
  input  logic              trstN,
  input  scanCtl_t          ctl,
  input  logic              scanIn,
  output logic              scanOut,
  input  logic [GROUPS-1:0] enN,
  input  logic [GROUPS-1:0] dir,
  input  logic [W-1:0]      aIn,
  input  logic [W-1:0]      bIn,
  input  logic [GROUPS-1:0] aOeF,
  input  logic [GROUPS-1:0] bOeF,
  input  logic [W-1:0]      aDatF,
  input  logic [W-1:0]      bDatF,
  output logic [GROUPS-1:0] aEn,
  output logic [GROUPS-1:0] bEn,
  output logic [W-1:0]      aOut,
  output logic [W-1:0]      bOut
);
  logic [CH-1:0] chain, latchQ, obs;

  // Observed values: control cells on top, then A in, B out, B in, A out
  always_comb begin
    obs = '0;
    for (int g = 0; g < GROUPS; g++) begin
      obs[CH-1-4*g] = dir[g];
      obs[CH-2-4*g] = enN[g];
      obs[CH-3-4*g] = aOeF[g];
      obs[CH-4-4*g] = bOeF[g];
    end
    for (int k = 0; k < W; k++) begin
      obs[4*W-1-k] = aIn[k];
      obs[3*W-1-k] = bDatF[k];
      obs[2*W-1-k] = bIn[k];
      obs[W-1-k]   = aDatF[k];
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)       chain <= '0;
    else if (ctl.cap) chain <= obs;
    else if (ctl.sh)  chain <= {scanIn, chain[CH-1:1]};
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      latchQ  <= '0;
      scanOut <= 1'b0;
    end else begin
      scanOut <= chain[0];
      if (ctl.upd) latchQ <= chain;
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : gEn
    assign aEn[g] = ctl.forceOff ? 1'b0 : (ctl.useLatch ? latchQ[CH-3-4*g] : aOeF[g]);
    assign bEn[g] = ctl.forceOff ? 1'b0 : (ctl.useLatch ? latchQ[CH-4-4*g] : bOeF[g]);

    a_r1_disabled_group_off: assert property (@(posedge tck) disable iff (!trstN)
      (!ctl.useLatch && !ctl.forceOff && enN[g]) |-> (!aEn[g] && !bEn[g]));
    a_r2_no_contention: assert property (@(posedge tck) disable iff (!trstN)
      (!ctl.useLatch) |-> !(aEn[g] && bEn[g]));
  end

  for (genvar k = 0; k < W; k++) begin : gDat
    assign aOut[k] = ctl.useLatch ? latchQ[W-1-k]   : aDatF[k];
    assign bOut[k] = ctl.useLatch ? latchQ[3*W-1-k] : bDatF[k];
  end

  a_r9_off_mode: assert property (@(posedge tck) disable iff (!trstN)
    ctl.forceOff |-> (aEn == '0 && bEn == '0));
  a_r5_shift_step: assert property (@(posedge tck) disable iff (!trstN)
    ctl.sh |=> (chain[CH-1] == $past(scanIn) && chain[CH-2:0] == $past(chain[CH-1:1])));
  a_r6_latch_hold: assert property (@(negedge tck) disable iff (!trstN)
    !ctl.upd |-> ##1 $stable(latchQ));
endmodule

// File: rtl/scan_bus_xcvr.sv
`timescale 1ns/1ps
module scan_bus_xcvr
  import scan_xcvr_pkg::*;
#(
  parameter int GROUPS = 2,
  parameter int GBITS  = 9,
  localparam int W = GROUPS * GBITS
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic [GROUPS-1:0] grpEnN,
  input  logic [GROUPS-1:0] grpDir,
  input  logic [W-1:0]      aIn,
  input  logic [W-1:0]      bIn,
  output logic [W-1:0]      aOut,
  output logic [W-1:0]      bOut,
  output logic [GROUPS-1:0] aEn,
  output logic [GROUPS-1:0] bEn,
  input  logic              capture,
  input  logic              shift,
  input  logic              update,
  input  logic [1:0]        mode,
  input  logic              scanIn,
  output logic              scanOut
);
  scanCtl_t          ctl;
  logic [GROUPS-1:0] aOeF, bOeF;
  logic [W-1:0]      aDatF, bDatF;

  xcvr_func #(.GROUPS(GROUPS), .GBITS(GBITS)) uFunc (
    .enN(grpEnN), .dir(grpDir), .aIn(aIn), .bIn(bIn),
    .aOeF(aOeF), .bOeF(bOeF), .aDatF(aDatF), .bDatF(bDatF));

  scan_ctrl uCtrl (
    .capture(capture), .shift(shift), .update(update), .mode(mode), .ctl(ctl));

  scan_path #(.GROUPS(GROUPS), .GBITS(GBITS)) uPath (
    .tck(tck), .trstN(trstN), .ctl(ctl), .scanIn(scanIn), .scanOut(scanOut),
    .enN(grpEnN), .dir(grpDir), .aIn(aIn), .bIn(bIn),
    .aOeF(aOeF), .bOeF(bOeF), .aDatF(aDatF), .bDatF(bDatF),
    .aEn(aEn), .bEn(bEn), .aOut(aOut), .bOut(bOut));
endmodule

// File: tb/tb_scan_bus_xcvr.sv
`timescale 1ns/1ps
module tb_scan_bus_xcvr;
  logic tck = 1'b0, trstN = 1'b0;
  logic [1:0] grpEnN, grpDir, aEn, bEn, mode;
  logic [17:0] aIn, bIn, aOut, bOut;
  logic capture, shift, update, scanIn, scanOut;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #5 tck = ~tck;

  scan_bus_xcvr dut (.tck(tck), .trstN(trstN), .grpEnN(grpEnN), .grpDir(grpDir),
    .aIn(aIn), .bIn(bIn), .aOut(aOut), .bOut(bOut), .aEn(aEn), .bEn(bEn),
    .capture(capture), .shift(shift), .update(update), .mode(mode),
    .scanIn(scanIn), .scanOut(scanOut));

  typedef struct packed {
    logic [1:0] enN, dir;
    logic [17:0] a, b;
    logic [1:0] eA, eB;
  } vec_t;

  // R1/R2/R3 functional vectors
  localparam vec_t VECS [6] = '{
    '{2'b11, 2'b00, 18'h3FFFF, 18'h00000, 2'b00, 2'b00},
    '{2'b00, 2'b11, 18'h15555, 18'h2AAAA, 2'b00, 2'b11},
    '{2'b00, 2'b00, 18'h0F0F0, 18'h30C3C, 2'b11, 2'b00},
    '{2'b00, 2'b01, 18'h12345, 18'h2BCDE, 2'b10, 2'b01},
    '{2'b01, 2'b10, 18'h00001, 18'h20000, 2'b00, 2'b10},
    '{2'b10, 2'b00, 18'h3C001, 18'h003FF, 2'b01, 2'b00}
  };
  localparam logic [79:0] PAT = 80'hA5F0_3C96_E17B_4D28_9C35;

  task automatic check(string req, logic [79:0] act, logic [79:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One full clock: strobes seen at the rising edge, update at the falling edge
  task automatic tick(logic c, logic s, logic u, logic si);
    capture = c; shift = s; update = u; scanIn = si;
    @(negedge tck); #2;
  endtask

  function automatic logic [79:0] expCap(logic [1:0] en, logic [1:0] dr, logic [17:0] a, logic [17:0] b);
    logic [79:0] v = '0;
    for (int g = 0; g < 2; g++) begin
      v[79-4*g] = dr[g];
      v[78-4*g] = en[g];
      v[77-4*g] = ~en[g] & ~dr[g];
      v[76-4*g] = ~en[g] & dr[g];
    end
    for (int k = 0; k < 18; k++) begin
      v[71-k] = a[k]; v[53-k] = a[k]; v[35-k] = b[k]; v[17-k] = b[k];
    end
    return v;
  endfunction

  function automatic logic [79:0] expLatchPads(logic [79:0] p);
    logic [1:0] ea, eb;
    logic [17:0] ao, bo;
    for (int g = 0; g < 2; g++) begin ea[g] = p[77-4*g]; eb[g] = p[76-4*g]; end
    for (int k = 0; k < 18; k++) begin bo[k] = p[53-k]; ao[k] = p[17-k]; end
    return {40'd0, ea, eb, ao, bo};
  endfunction

  function automatic logic [79:0] pads();
    return {40'd0, aEn, bEn, aOut, bOut};
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [79:0] got;
    grpEnN = 2'b11; grpDir = 2'b00; aIn = '0; bIn = '0; mode = 2'd1;
    capture = 0; shift = 0; update = 0; scanIn = 0;
    #23;
    // R10: reset state, pads come from cleared latches in mode 1
    check("R10 scanOut", {79'd0, scanOut}, 80'd0);
    check("R10 latch pads", pads(), 80'd0);
    trstN = 1'b1;
    @(negedge tck); #2;
    tick(0, 0, 0, 0);
    check("R10 after release", {79'd0, scanOut}, 80'd0);

    // R1 R2 R3 table walk in functional mode
    mode = 2'd0;
    foreach (VECS[i]) begin
      grpEnN = VECS[i].enN; grpDir = VECS[i].dir; aIn = VECS[i].a; bIn = VECS[i].b;
      tick(0, 0, 0, 0);
      check("R1/R2/R3 functional", pads(), {40'd0, VECS[i].eA, VECS[i].eB, VECS[i].b, VECS[i].a});
    end

    // R4 capture, R5 serial order, shifting PAT in meanwhile
    grpEnN = 2'b10; grpDir = 2'b01; aIn = 18'h2A5C3; bIn = 18'h1B34F;
    tick(1, 0, 0, 0);
    for (int i = 0; i < 80; i++) begin
      got[i] = scanOut;
      tick(0, 1, 0, PAT[i]);
    end
    check("R4 capture map", got, expCap(2'b10, 2'b01, 18'h2A5C3, 18'h1B34F));
    // R8: scan activity in mode 0 leaves pads functional
    tick(0, 0, 1, 0);
    check("R8 mode0 pads undisturbed", pads(), {40'd0, 2'b00, 2'b01, 18'h1B34F, 18'h2A5C3});

    // R7 latch mode decodes the updated pattern
    mode = 2'd1;
    tick(0, 0, 0, 0);
    check("R7 latch pads", pads(), expLatchPads(PAT));

    // R5 shift PAT back out; R6 latches hold without update
    for (int i = 0; i < 80; i++) begin
      got[i] = scanOut;
      tick(0, 1, 0, 1'b0);
    end
    check("R5 serial readback", got, PAT);
    check("R6 hold without update", pads(), expLatchPads(PAT));
    tick(0, 0, 1, 0);
    check("R6 update zeros", pads(), 80'd0);

    // R9 off mode and spare mode code
    mode = 2'd2; grpEnN = 2'b00; grpDir = 2'b01;
    tick(0, 0, 0, 0);
    check("R9 off mode", pads(), {40'd0, 2'b00, 2'b00, 18'h1B34F, 18'h2A5C3});
    mode = 2'd3;
    tick(0, 0, 0, 0);
    check("R9 mode3 functional", pads(), {40'd0, 2'b10, 2'b01, 18'h1B34F, 18'h2A5C3});

    finishRun();
  end
endmodule